// File: doc/BRIEF.md
# USB Controller Interrupt Aggregator

This block collects interrupt events for a USB controller core and presents them to a processor as one interrupt line behind a small 32-bit register port. Single-cycle event pulses from the transmit endpoints, the receive endpoints and the core are latched into a source register. Each logic level change on the VBUS drive signal also raises an event. Software can set or clear source bits on purpose. It enables bits through a mask, and it reads the raw source, the mask, and the AND of the two.

The interrupt line works as a one-shot gate. Once it has fired, it cannot fire again until software writes the end-of-interrupt register. This means a handler that clears its sources and then writes end-of-interrupt gets exactly one new assertion for each service round. A revision register reads a fixed nonzero value. A status register reports the live VBUS drive level. A control bit issues a one-cycle soft reset of the whole event path.

Top module: `usbirq_shell`

## Requirements
- R1: Reading offset 0x00 returns the parameter REV_ID, which is nonzero (default 32'h4EA1_0C05).
- R2: Reading offset 0x08 returns the current vbus_drive level in bit 0 and zero in all other bits.
- R3: A one-cycle pulse on tx_evt[i] sets source bit i. A pulse on rx_evt[i] sets bit 9+i. A pulse on core_evt[i] sets bit 16+i. The bit stays set until it is cleared. Bits outside 0–4, 9–12 and 16–24 always read 0.
- R4: A write to 0x24 (source set) or 0x30 (mask set) sets the bits written as 1. A write to 0x28 (source clear) or 0x34 (mask clear) clears the bits written as 1. Bits written as 0 keep their value. Reads of 0x20, 0x24 and 0x28 return the source. Reads of 0x2C, 0x30 and 0x34 return the mask.
- R5: When a hardware event and a source-clear write hit the same bit in the same cycle, the bit ends up set.
- R6: Reading 0x38 returns the source AND the mask.
- R7: Every change of vbus_drive, rising or falling, sets source bit 24.
- R8: When the gate is armed and the masked source is nonzero, irq rises one cycle later. irq stays high while the masked source is nonzero and falls one cycle after the masked source becomes zero.
- R9: After irq has fired, it stays low until an end-of-interrupt write, even when new masked bits appear.
- R10: A write of any value to 0x3C re-arms the gate. If the masked source is then nonzero, irq rises on the next cycle. Otherwise irq waits for a new masked bit.
- R11: Writing 1 to bit 0 of 0x04 sets a soft-reset pulse. Bit 0 of 0x04 reads as 1 only for that single cycle. The pulse clears the source and the mask, drops irq and re-arms the gate. Writing 0 to bit 0 has no effect.
- R12: Read data appears on the cycle after bus_rd. Offset 0x3C and unmapped offsets read as 0. Writes to 0x20 and 0x2C are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tx_evt | input | 5 | Transmit-side event pulses |
| rx_evt | input | 4 | Receive-endpoint event pulses |
| core_evt | input | 8 | Core event pulses |
| vbus_drive | input | 1 | VBUS drive level |
| irq | output | 1 | Gated interrupt line |

## Verification
The hardest state to reach from the ports is a masked source that is pending while irq is held low because no end-of-interrupt has been written. The bench gets there by letting irq fire once, clearing the source, and then pulsing a new event. It holds that state for several cycles before it re-arms the gate with an arbitrary value. The same-cycle race between a hardware event and a source-clear write also needs care. The bench drives the event pulse and the clear write at the same negative edge, so that both land on one clock edge.

// File: rtl/usbirq_pkg.sv
package usbirq_pkg;
  localparam int unsigned REG_W = 32;

  localparam logic [7:0] OFS_REV    = 8'h00;
  localparam logic [7:0] OFS_CTRL   = 8'h04;
  localparam logic [7:0] OFS_STAT   = 8'h08;
  localparam logic [7:0] OFS_SRC    = 8'h20;
  localparam logic [7:0] OFS_SSET   = 8'h24;
  localparam logic [7:0] OFS_SCLR   = 8'h28;
  localparam logic [7:0] OFS_MSK    = 8'h2C;
  localparam logic [7:0] OFS_MSET   = 8'h30;
  localparam logic [7:0] OFS_MCLR   = 8'h34;
  localparam logic [7:0] OFS_MASKED = 8'h38;
  localparam logic [7:0] OFS_EOI    = 8'h3C;

  // contiguous field of n ones starting at bit lsb
  function automatic logic [REG_W-1:0] field_mask(int unsigned lsb, int unsigned n);
    logic [63:0] m;
    m = ((64'd1 << n) - 64'd1) << lsb;
    return m[REG_W-1:0];
  endfunction
endpackage

// File: rtl/usbirq_srcbank.sv
module usbirq_srcbank
  import usbirq_pkg::*;
#(
  parameter logic [REG_W-1:0] VALID = 32'h01FF_1E1F
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             srst,
  input  logic [REG_W-1:0] hw_evt,
  input  logic [REG_W-1:0] set_src,
  input  logic [REG_W-1:0] clr_src,
  input  logic [REG_W-1:0] set_msk,
  input  logic [REG_W-1:0] clr_msk,
  output logic [REG_W-1:0] src_q,
  output logic [REG_W-1:0] mask_q
);
  for (genvar i = 0; i < REG_W; i++) begin : g_bit
    if (VALID[i]) begin : g_live
      always_ff @(posedge clk) begin
        if (rst || srst) begin
          src_q[i]  <= 1'b0;
          mask_q[i] <= 1'b0;
        end else begin
          // clear first, then set and hardware event, so an event beats a clear
          src_q[i]  <= (src_q[i] & ~clr_src[i]) | set_src[i] | hw_evt[i];
          mask_q[i] <= (mask_q[i] & ~clr_msk[i]) | set_msk[i];
        end
      end
    end else begin : g_tie
      assign src_q[i]  = 1'b0;
      assign mask_q[i] = 1'b0;
    end
  end
endmodule

// File: rtl/usbirq_gate.sv
module usbirq_gate (
  input  logic clk,
  input  logic rst,
  input  logic srst,
  input  logic pend,
  input  logic eoi,
  output logic irq,
  output logic armed
);
  always_ff @(posedge clk) begin
    if (rst || srst) begin
      irq   <= 1'b0;
      armed <= 1'b1;
    end else begin
      if (!irq && armed && pend) begin
        irq   <= 1'b1;
        armed <= 1'b0;
      end else if (irq && !pend) begin
        irq <= 1'b0;
      end
      if (eoi) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/usbirq_regif.sv
module usbirq_regif
  import usbirq_pkg::*;
#(
  parameter int unsigned      ADDR_W = 8,
  parameter logic [REG_W-1:0] REV_ID = 32'h4EA1_0C05
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic [REG_W-1:0]  src_q,
  input  logic [REG_W-1:0]  mask_q,
  input  logic              vbus_lvl,
  output logic [REG_W-1:0]  set_src,
  output logic [REG_W-1:0]  clr_src,
  output logic [REG_W-1:0]  set_msk,
  output logic [REG_W-1:0]  clr_msk,
  output logic              eoi,
  output logic              srst_q,
  output logic [REG_W-1:0]  bus_rdata
);
  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  logic ctrl_set;

  always_comb begin
    set_src  = (bus_wr && hit(bus_addr, OFS_SSET)) ? bus_wdata : '0;
    clr_src  = (bus_wr && hit(bus_addr, OFS_SCLR)) ? bus_wdata : '0;
    set_msk  = (bus_wr && hit(bus_addr, OFS_MSET)) ? bus_wdata : '0;
    clr_msk  = (bus_wr && hit(bus_addr, OFS_MCLR)) ? bus_wdata : '0;
    eoi      = bus_wr && hit(bus_addr, OFS_EOI);
    ctrl_set = bus_wr && hit(bus_addr, OFS_CTRL) && bus_wdata[0];
  end

  always_ff @(posedge clk) begin
    if (rst) srst_q <= 1'b0;
    else     srst_q <= ctrl_set;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (hit(bus_addr, OFS_REV))
        bus_rdata <= REV_ID;
      else if (hit(bus_addr, OFS_CTRL))
        bus_rdata <= {{(REG_W-1){1'b0}}, srst_q};
      else if (hit(bus_addr, OFS_STAT))
        bus_rdata <= {{(REG_W-1){1'b0}}, vbus_lvl};
      else if (hit(bus_addr, OFS_SRC) || hit(bus_addr, OFS_SSET) || hit(bus_addr, OFS_SCLR))
        bus_rdata <= src_q;
      else if (hit(bus_addr, OFS_MSK) || hit(bus_addr, OFS_MSET) || hit(bus_addr, OFS_MCLR))
        bus_rdata <= mask_q;
      else if (hit(bus_addr, OFS_MASKED))
        bus_rdata <= src_q & mask_q;
      else
        bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/usbirq_shell.sv
module usbirq_shell
  import usbirq_pkg::*;
#(
  parameter int unsigned      ADDR_W   = 8,
  parameter int unsigned      TX_N     = 5,
  parameter int unsigned      RX_N     = 4,
  parameter int unsigned      CORE_N   = 9,
  parameter int unsigned      TX_LSB   = 0,
  parameter int unsigned      RX_LSB   = 9,
  parameter int unsigned      CORE_LSB = 16,
  parameter logic [REG_W-1:0] REV_ID   = 32'h4EA1_0C05
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [TX_N-1:0]   tx_evt,
  input  logic [RX_N-1:0]   rx_evt,
  input  logic [CORE_N-2:0] core_evt,
  input  logic              vbus_drive,
  output logic              irq
);
  localparam logic [REG_W-1:0] VALID = field_mask(TX_LSB, TX_N)
                                     | field_mask(RX_LSB, RX_N)
                                     | field_mask(CORE_LSB, CORE_N);

  logic [REG_W-1:0] src_q, mask_q, hw_vec;
  logic [REG_W-1:0] set_src, clr_src, set_msk, clr_msk;
  logic             eoi_wr, srst_q, armed, vbus_prev, vbus_chg;

  always_ff @(posedge clk) begin
    if (rst) vbus_prev <= 1'b0;
    else     vbus_prev <= vbus_drive;
  end
  assign vbus_chg = vbus_drive ^ vbus_prev;

  assign hw_vec = (REG_W'(tx_evt) << TX_LSB)
                | (REG_W'(rx_evt) << RX_LSB)
                | (REG_W'({vbus_chg, core_evt}) << CORE_LSB);

  usbirq_regif #(.ADDR_W(ADDR_W), .REV_ID(REV_ID)) u_regif (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .src_q(src_q), .mask_q(mask_q), .vbus_lvl(vbus_drive),
    .set_src(set_src), .clr_src(clr_src), .set_msk(set_msk), .clr_msk(clr_msk),
    .eoi(eoi_wr), .srst_q(srst_q), .bus_rdata(bus_rdata)
  );

  usbirq_srcbank #(.VALID(VALID)) u_bank (
    .clk(clk), .rst(rst), .srst(srst_q), .hw_evt(hw_vec),
    .set_src(set_src), .clr_src(clr_src), .set_msk(set_msk), .clr_msk(clr_msk),
    .src_q(src_q), .mask_q(mask_q)
  );

  usbirq_gate u_gate (
    .clk(clk), .rst(rst), .srst(srst_q), .pend(|(src_q & mask_q)),
    .eoi(eoi_wr), .irq(irq), .armed(armed)
  );
endmodule

// File: rtl/usbirq_shell_chk.sv
module usbirq_shell_chk
  import usbirq_pkg::*;
#(
  parameter int unsigned      ADDR_W = 8,
  parameter logic [REG_W-1:0] REV_ID = 32'h4EA1_0C05,
  parameter logic [REG_W-1:0] VALID  = 32'h01FF_1E1F
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [REG_W-1:0]  bus_wdata,
  input logic [REG_W-1:0]  bus_rdata,
  input logic [REG_W-1:0]  src_q,
  input logic [REG_W-1:0]  mask_q,
  input logic [REG_W-1:0]  hw_vec,
  input logic              srst_q,
  input logic              armed,
  input logic              irq
);
  logic eoi_w, ctrl_w;
  assign eoi_w  = bus_wr && bus_addr == ADDR_W'(OFS_EOI);
  assign ctrl_w = bus_wr && bus_addr == ADDR_W'(OFS_CTRL) && bus_wdata[0];

  a_r1_rev_value: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(OFS_REV)) |=> bus_rdata == REV_ID && bus_rdata != '0);

  a_r5_event_beats_clear: assert property (@(posedge clk) disable iff (rst)
    ((hw_vec & VALID) != '0 && !srst_q) |=> (src_q & $past(hw_vec & VALID)) == $past(hw_vec & VALID));

  a_r6_masked_read: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(OFS_MASKED)) |=> bus_rdata == $past(src_q & mask_q));

  a_r8_fire_when_armed: assert property (@(posedge clk) disable iff (rst)
    (armed && (src_q & mask_q) != '0 && !srst_q) |=> irq);

  a_r9_quiet_until_eoi: assert property (@(posedge clk) disable iff (rst)
    (!irq && !armed && !eoi_w) |=> !irq);

  a_r11_soft_reset_clears: assert property (@(posedge clk) disable iff (rst)
    srst_q |=> (src_q == '0 && mask_q == '0 && !irq && armed));

  a_r11_pulse_one_cycle: assert property (@(posedge clk) disable iff (rst)
    (srst_q && !ctrl_w) |=> !srst_q);

  a_r3_unused_bits_zero: assert property (@(posedge clk) disable iff (rst)
    ((src_q | mask_q) & ~VALID) == '0);
endmodule

bind usbirq_shell usbirq_shell_chk #(.ADDR_W(ADDR_W), .REV_ID(REV_ID), .VALID(VALID)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_q(src_q), .mask_q(mask_q),
  .hw_vec(hw_vec), .srst_q(srst_q), .armed(armed), .irq(irq)
);

// File: tb/usbirq_shell_test.sv
module usbirq_shell_test;
  localparam logic [31:0] VALID = 32'h01FF_1E1F;
  localparam logic [31:0] REV   = 32'h4EA1_0C05;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [4:0]  tx_evt = '0;
  logic [3:0]  rx_evt = '0;
  logic [7:0]  core_evt = '0;
  logic        vbus_drive = 1'b0;
  logic        irq;
  int          total = 0, bad = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  usbirq_shell uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_evt(tx_evt), .rx_evt(rx_evt),
    .core_evt(core_evt), .vbus_drive(vbus_drive), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    step();
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'h0155_1A15; pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'h0100_0001; pats[3] = 32'h00AA_0C0A;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    chk("R8 reset irq", {31'b0, irq}, 0);
    rd(8'h00, rv); chk("R1 revision", rv, REV);
    rd(8'h20, rv); chk("R12 reset source", rv, 0);
    rd(8'h2C, rv); chk("R12 reset mask", rv, 0);
    rd(8'h04, rv); chk("R11 ctrl idle", rv, 0);

    rd(8'h08, rv); chk("R2 status low", rv, 0);
    vbus_drive = 1'b1; step();
    rd(8'h08, rv); chk("R2 status high", rv, 1);
    rd(8'h20, rv); chk("R7 vbus rise event", rv, 32'h0100_0000);
    wr(8'h28, 32'hFFFF_FFFF);
    rd(8'h20, rv); chk("R4 clear all", rv, 0);
    vbus_drive = 1'b0; step();
    rd(8'h20, rv); chk("R7 vbus fall event", rv, 32'h0100_0000);
    wr(8'h28, 32'hFFFF_FFFF);

    for (int i = 0; i < 32; i++) begin
      wr(8'h24, 32'd1 << i);
      rd(8'h20, rv); chk($sformatf("R3 set bit %0d", i), rv, (32'd1 << i) & VALID);
      rd(8'h24, rv); chk("R4 set alias read", rv, (32'd1 << i) & VALID);
      rd(8'h28, rv); chk("R4 clear alias read", rv, (32'd1 << i) & VALID);
      wr(8'h28, 32'd1 << i);
      rd(8'h20, rv); chk("R4 clear bit", rv, 0);
      chk("R8 no irq with zero mask", {31'b0, irq}, 0);
    end

    for (int i = 0; i < 5; i++) begin
      tx_evt[i] = 1'b1; step(); tx_evt = '0;
      rd(8'h20, rv); chk($sformatf("R3 tx pulse %0d", i), rv, 32'd1 << i);
      wr(8'h28, 32'hFFFF_FFFF);
    end
    for (int i = 0; i < 4; i++) begin
      rx_evt[i] = 1'b1; step(); rx_evt = '0;
      rd(8'h20, rv); chk($sformatf("R3 rx pulse %0d", i), rv, 32'd1 << (9 + i));
      wr(8'h28, 32'hFFFF_FFFF);
    end
    for (int i = 0; i < 8; i++) begin
      core_evt[i] = 1'b1; step(); core_evt = '0;
      rd(8'h20, rv); chk($sformatf("R3 core pulse %0d", i), rv, 32'd1 << (16 + i));
      wr(8'h28, 32'hFFFF_FFFF);
    end

    wr(8'h24, 32'h0000_1E1F); wr(8'h28, 32'h0000_0015);
    rd(8'h20, rv); chk("R4 partial clear", rv, 32'h0000_1E0A);
    wr(8'h28, 32'hFFFF_FFFF);

    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h2C, rv); chk("R4 mask set all", rv, VALID);
    wr(8'h34, 32'h00FF_0000);
    rd(8'h2C, rv); chk("R4 mask partial clear", rv, 32'h0100_1E1F);
    rd(8'h30, rv); chk("R4 mask alias read", rv, 32'h0100_1E1F);
    wr(8'h2C, 32'h0);
    rd(8'h2C, rv); chk("R12 mask direct write ignored", rv, 32'h0100_1E1F);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, rv); chk("R12 source direct write ignored", rv, 0);

    for (int p = 0; p < 4; p++) begin
      wr(8'h28, 32'hFFFF_FFFF);
      wr(8'h24, pats[p]);
      rd(8'h38, rv); chk($sformatf("R6 masked pattern %0d", p), rv, pats[p] & VALID & 32'h0100_1E1F);
    end

    wr(8'h04, 32'h1);
    rd(8'h04, rv); chk("R11 ctrl pulse visible", rv, 1);
    rd(8'h04, rv); chk("R11 ctrl self clear", rv, 0);
    rd(8'h20, rv); chk("R11 source cleared", rv, 0);
    rd(8'h2C, rv); chk("R11 mask cleared", rv, 0);
    chk("R11 irq low", {31'b0, irq}, 0);
    wr(8'h24, 32'h1); wr(8'h04, 32'h0); step();
    rd(8'h20, rv); chk("R11 ctrl zero no reset", rv, 1);
    wr(8'h28, 32'hFFFF_FFFF);

    wr(8'h30, 32'h1);
    tx_evt[0] = 1'b1; step(); tx_evt = '0;
    chk("R8 latency one cycle", {31'b0, irq}, 0);
    step(); chk("R8 irq rises", {31'b0, irq}, 1);
    repeat (3) step();
    chk("R8 irq holds", {31'b0, irq}, 1);
    wr(8'h28, 32'h1);
    chk("R8 irq still high at clear", {31'b0, irq}, 1);
    step(); chk("R8 irq falls", {31'b0, irq}, 0);
    tx_evt[0] = 1'b1; step(); tx_evt = '0;
    repeat (5) step();
    chk("R9 no refire without eoi", {31'b0, irq}, 0);
    rd(8'h38, rv); chk("R9 pending visible", rv, 1);
    wr(8'h3C, 32'h0000_1234);
    chk("R10 eoi latency", {31'b0, irq}, 0);
    step(); chk("R10 refire after eoi", {31'b0, irq}, 1);
    wr(8'h28, 32'h1); step();
    chk("R8 drop after clear", {31'b0, irq}, 0);
    wr(8'h3C, 32'h0);
    repeat (4) step();
    chk("R10 armed but idle", {31'b0, irq}, 0);
    tx_evt[0] = 1'b1; step(); tx_evt = '0;
    chk("R10 armed latency", {31'b0, irq}, 0);
    step(); chk("R10 fires on new event", {31'b0, irq}, 1);

    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h24, 32'h1);
    tx_evt = 5'b00010; bus_wr = 1'b1; bus_addr = 8'h28; bus_wdata = 32'h3;
    step();
    tx_evt = '0; bus_wr = 1'b0;
    rd(8'h20, rv); chk("R5 event beats clear", rv, 32'h2);

    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h3C, 32'h0);
    wr(8'h24, 32'h1); step();
    chk("R8 irq before soft reset", {31'b0, irq}, 1);
    wr(8'h04, 32'h1); step();
    chk("R11 soft reset drops irq", {31'b0, irq}, 0);
    rd(8'h2C, rv); chk("R11 mask zero after reset", rv, 0);
    wr(8'h30, 32'h1); wr(8'h24, 32'h1);
    chk("R11 rearm latency", {31'b0, irq}, 0);
    step(); chk("R11 rearmed without eoi", {31'b0, irq}, 1);

    rd(8'h44, rv); chk("R12 unmapped reads zero", rv, 0);
    rd(8'h3C, rv); chk("R12 eoi reads zero", rv, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule